// File: doc/BRIEF.md
# Line Nonuniformity Group Statistics

This block scores how evenly a linear image sensor responds to flat, uniform light. It takes one line of effective pixel samples as a stream and splits it into consecutive groups of fixed length. With the defaults, 2700 pixels form 27 groups of 100. For each group it records the largest sample, the smallest sample and the sample sum. It then reports a nonuniformity score equal to half the max-to-min spread divided by the group mean, expressed as a percentage.

The score is a fixed-point code in units of 0.5 percent: `code = floor((max - min) * 100 * GROUP_LEN / sum)`. The exact mean `sum / GROUP_LEN` is used, so no precision is lost to a truncated average. A sequential restoring divider computes the quotient. Each group result leaves on a valid/ready handshake. After the final group, the block pulses a line summary carrying the worst group, its score, and a pass/fail verdict against a programmable limit. A typical pass limit is 20 percent, which is code 40; sensors typically score around 4 percent, which is code 8.

Input back-pressure works as follows. `in_ready` is high only while the block is gathering a group. It drops in the cycle after the last pixel of a group is accepted, and it stays low through the divide and until the group result is taken. An upstream source must hold `in_valid`, `in_data` and `in_sol` while `in_ready` is low. Once `res_valid` is high, the result fields stay fixed until `res_ready` is seen.

Top module: `prnu_stats`

## Requirements
- R1: After reset, `in_ready` is 1 and `res_valid` and `line_done` are 0.
- R2: Accepted pixels that arrive before any pixel marked with `in_sol` are discarded and never produce a result.
- R3: A pixel accepted with `in_sol` = 1 starts group 0 of a new line. Every GROUP_LEN accepted pixels close one group, and the results carry `res_idx` values 0, 1, … NUM_GROUPS−1 in order.
- R4: For a group with nonzero sum, `res_code` equals floor((max − min) × 100 × GROUP_LEN / sum) in units of 0.5 percent, and `res_err` is 0.
- R5: A group whose sum is zero gives `res_code` of all ones and `res_err` = 1.
- R6: `in_ready` is 0 while `res_valid` is 1. A pending result holds `res_idx`, `res_code` and `res_err` unchanged until `res_ready` is high.
- R7: `line_done` pulses for exactly one cycle, in the cycle after the handshake of group NUM_GROUPS−1. In that cycle it presents the largest group score and its index, and among equal scores the lowest index wins.
- R8: During the `line_done` pulse, `line_fail` is 1 exactly when the worst code is strictly greater than `limit`.
- R9: After a line completes, accepted pixels without `in_sol` are discarded until the next `in_sol`.
- R10: A quotient that exceeds 2^RES_W − 1 is clamped to all ones with `res_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Pixel sample valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_data | input | DATA_W | Pixel sample value |
| in_sol | input | 1 | Marks the first pixel of a line |
| res_valid | output | 1 | Group result available |
| res_ready | input | 1 | Consumer takes the group result |
| res_idx | output | IDX_W | Index of the group within the line |
| res_code | output | RES_W | Group score in 0.5 percent units |
| res_err | output | 1 | Group sum was zero |
| limit | input | RES_W | Fail threshold in 0.5 percent units |
| line_done | output | 1 | One-cycle end-of-line pulse |
| worst_idx | output | IDX_W | Index of the highest-scoring group |
| worst_code | output | RES_W | Highest group score of the line |
| line_fail | output | 1 | Worst score exceeds `limit` |

## Verification
The assertions rely on the consumer keeping `res_ready` low for as many cycles as it wants without the block ever dropping a result. They also rely on GROUP_LEN being at least 2, so that two end-of-line pulses can never fall in adjacent cycles. The stimulus drives lines in a small configuration and holds each pixel until `in_ready` accepts it. It stalls the result consumer for zero to two cycles in a pattern that rotates with the group number. Every expected score comes from the closed-form formula, evaluated on the very samples that were sent.

// File: rtl/prnu_pkg.sv
package prnu_pkg;

  typedef enum logic [1:0] {
    ST_GATHER = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_DIVIDE = 2'd2,
    ST_REPORT = 2'd3
  } prnu_state_e;

endpackage

// File: rtl/prnu_group_acc.sv
module prnu_group_acc #(
  parameter int DATA_W    = 12,
  parameter int GROUP_LEN = 100,
  parameter int SUM_W     = 19,
  parameter int CNT_W     = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic              restart,
  input  logic [DATA_W-1:0] pix,
  output logic [DATA_W-1:0] grp_max,
  output logic [DATA_W-1:0] grp_min,
  output logic [SUM_W-1:0]  grp_sum,
  output logic              last_px
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pos;
  logic             first;

  assign pos     = restart ? '0 : cnt_q;
  assign first   = (pos == '0);
  assign last_px = take && (pos == CNT_W'(GROUP_LEN - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      grp_max <= '0;
      grp_min <= '0;
      grp_sum <= '0;
    end else if (take) begin
      cnt_q <= (pos == CNT_W'(GROUP_LEN - 1)) ? '0 : pos + 1'b1;
      if (first) begin
        grp_max <= pix;
        grp_min <= pix;
        grp_sum <= SUM_W'(pix);
      end else begin
        if (pix > grp_max) grp_max <= pix;
        if (pix < grp_min) grp_min <= pix;
        grp_sum <= grp_sum + SUM_W'(pix);
      end
    end
  end

  // R3: once a group has started, its minimum never exceeds its maximum
  a_r3_min_le_max: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> (grp_min <= grp_max));

endmodule

// File: rtl/prnu_divider.sv
module prnu_divider #(
  parameter int NUM_W = 26,
  parameter int DEN_W = 19
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quot
);

  localparam int STEP_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0]  rem_q;
  logic [DEN_W-1:0]  den_q;
  logic [NUM_W-1:0]  sh_q;
  logic [STEP_W-1:0] steps_q;
  logic              busy_q;
  logic [DEN_W:0]    trial;
  logic              fits;

  assign trial = {rem_q, sh_q[NUM_W-1]};
  assign fits  = (trial >= {1'b0, den_q});
  assign quot  = sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q   <= '0;
      den_q   <= '0;
      sh_q    <= '0;
      steps_q <= '0;
      busy_q  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        rem_q   <= '0;
        den_q   <= den;
        sh_q    <= num;
        steps_q <= STEP_W'(NUM_W);
        busy_q  <= 1'b1;
      end else if (busy_q) begin
        if (fits) begin
          rem_q <= DEN_W'(trial - {1'b0, den_q});
          sh_q  <= {sh_q[NUM_W-2:0], 1'b1};
        end else begin
          rem_q <= trial[DEN_W-1:0];
          sh_q  <= {sh_q[NUM_W-2:0], 1'b0};
        end
        steps_q <= steps_q - 1'b1;
        if (steps_q == STEP_W'(1)) begin
          busy_q <= 1'b0;
          done   <= 1'b1;
        end
      end
    end
  end

  // R4: the partial remainder of a nonzero divisor stays below it
  a_r4_rem_below_den: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && den_q != '0) |-> (rem_q < den_q));

endmodule

// File: rtl/prnu_worst.sv
module prnu_worst #(
  parameter int RES_W      = 10,
  parameter int IDX_W      = 5,
  parameter int NUM_GROUPS = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd,
  input  logic [IDX_W-1:0] idx,
  input  logic [RES_W-1:0] code,
  input  logic [RES_W-1:0] limit,
  output logic             done,
  output logic [IDX_W-1:0] w_idx,
  output logic [RES_W-1:0] w_code,
  output logic             fail
);

  logic             load;
  logic [RES_W-1:0] nxt_code;
  logic             is_last;

  assign load     = (idx == '0) || (code > w_code);
  assign nxt_code = load ? code : w_code;
  assign is_last  = (idx == IDX_W'(NUM_GROUPS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      w_idx  <= '0;
      w_code <= '0;
      fail   <= 1'b0;
    end else begin
      done <= upd && is_last;
      if (upd) begin
        if (load) begin
          w_idx  <= idx;
          w_code <= code;
        end
        if (is_last) fail <= (nxt_code > limit);
      end
    end
  end

  // R7: the end-of-line pulse lasts a single cycle
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: rtl/prnu_stats.sv
module prnu_stats
  import prnu_pkg::*;
#(
  parameter int DATA_W     = 12,
  parameter int GROUP_LEN  = 100,
  parameter int NUM_GROUPS = 27,
  parameter int RES_W      = 10,
  localparam int IDX_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_sol,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [IDX_W-1:0]  res_idx,
  output logic [RES_W-1:0]  res_code,
  output logic              res_err,
  input  logic [RES_W-1:0]  limit,
  output logic              line_done,
  output logic [IDX_W-1:0]  worst_idx,
  output logic [RES_W-1:0]  worst_code,
  output logic              line_fail
);

  localparam int CNT_W    = $clog2(GROUP_LEN);
  localparam int SUM_W    = DATA_W + $clog2(GROUP_LEN + 1);
  localparam int SCALE    = 100 * GROUP_LEN;
  localparam int NUM_W    = DATA_W + $clog2(SCALE + 1);
  localparam int CODE_MAX = (1 << RES_W) - 1;

  prnu_state_e      state_q;
  logic             line_active_q;
  logic [IDX_W-1:0] idx_q;
  logic [RES_W-1:0] code_q;
  logic             err_q;

  logic              take;
  logic              use_px;
  logic              last_px;
  logic [DATA_W-1:0] grp_max;
  logic [DATA_W-1:0] grp_min;
  logic [SUM_W-1:0]  grp_sum;
  logic              div_start;
  logic              div_done;
  logic [NUM_W-1:0]  div_num;
  logic [NUM_W-1:0]  quot;
  logic              hs;
  logic              last_grp;

  assign in_ready  = (state_q == ST_GATHER);
  assign take      = in_valid && in_ready;
  assign use_px    = take && (in_sol || line_active_q);
  assign div_start = (state_q == ST_LAUNCH);
  assign div_num   = NUM_W'(grp_max - grp_min) * NUM_W'(SCALE);
  assign res_valid = (state_q == ST_REPORT);
  assign res_idx   = idx_q;
  assign res_code  = code_q;
  assign res_err   = err_q;
  assign hs        = res_valid && res_ready;
  assign last_grp  = (idx_q == IDX_W'(NUM_GROUPS - 1));

  prnu_group_acc #(
    .DATA_W(DATA_W), .GROUP_LEN(GROUP_LEN), .SUM_W(SUM_W), .CNT_W(CNT_W)
  ) u_acc (
    .clk(clk), .rst_n(rst_n), .take(use_px), .restart(in_sol),
    .pix(in_data), .grp_max(grp_max), .grp_min(grp_min),
    .grp_sum(grp_sum), .last_px(last_px)
  );

  prnu_divider #(.NUM_W(NUM_W), .DEN_W(SUM_W)) u_div (
    .clk(clk), .rst_n(rst_n), .start(div_start), .num(div_num),
    .den(grp_sum), .done(div_done), .quot(quot)
  );

  prnu_worst #(.RES_W(RES_W), .IDX_W(IDX_W), .NUM_GROUPS(NUM_GROUPS)) u_worst (
    .clk(clk), .rst_n(rst_n), .upd(hs), .idx(idx_q), .code(code_q),
    .limit(limit), .done(line_done), .w_idx(worst_idx),
    .w_code(worst_code), .fail(line_fail)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q       <= ST_GATHER;
      line_active_q <= 1'b0;
      idx_q         <= '0;
      code_q        <= '0;
      err_q         <= 1'b0;
    end else begin
      case (state_q)
        ST_GATHER: begin
          if (take && in_sol) begin
            line_active_q <= 1'b1;
            idx_q         <= '0;
          end
          if (use_px && last_px) state_q <= ST_LAUNCH;
        end
        ST_LAUNCH: state_q <= ST_DIVIDE;
        ST_DIVIDE: begin
          if (div_done) begin
            if (grp_sum == '0) begin
              code_q <= RES_W'(CODE_MAX);
              err_q  <= 1'b1;
            end else begin
              code_q <= (quot > NUM_W'(CODE_MAX)) ? RES_W'(CODE_MAX) : quot[RES_W-1:0];
              err_q  <= 1'b0;
            end
            state_q <= ST_REPORT;
          end
        end
        ST_REPORT: begin
          if (res_ready) begin
            state_q <= ST_GATHER;
            if (last_grp) begin
              line_active_q <= 1'b0;
              idx_q         <= '0;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        default: state_q <= ST_GATHER;
      endcase
    end
  end

  // R6: a stalled result keeps its fields
  a_r6_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_code) &&
                                   $stable(res_idx) && $stable(res_err)));

  // R6: no pixel is taken while a result is pending
  a_r6_no_intake: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> !in_ready);

  // R5: a zero-sum group reports the saturated code
  a_r5_zero_code: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_err) |-> (res_code == RES_W'(CODE_MAX)));

  // R3: reported indices stay inside the line
  a_r3_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (res_idx < IDX_W'(NUM_GROUPS)));

endmodule

// File: tb/prnu_stats_tb.sv
module prnu_stats_tb;

  localparam int DW = 8;
  localparam int N  = 4;
  localparam int G  = 3;
  localparam int RW = 8;
  localparam int IW = 2;
  localparam int T  = N * G;
  localparam int CMAX = (1 << RW) - 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [DW-1:0] in_data = '0;
  logic          in_sol = 1'b0;
  logic          res_valid;
  logic          res_ready = 1'b0;
  logic [IW-1:0] res_idx;
  logic [RW-1:0] res_code;
  logic          res_err;
  logic [RW-1:0] limit = 8'd40;
  logic          line_done;
  logic [IW-1:0] worst_idx;
  logic [RW-1:0] worst_code;
  logic          line_fail;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  int pix[T];

  always #5 clk = ~clk;

  prnu_stats #(.DATA_W(DW), .GROUP_LEN(N), .NUM_GROUPS(G), .RES_W(RW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_sol(in_sol), .res_valid(res_valid),
    .res_ready(res_ready), .res_idx(res_idx), .res_code(res_code),
    .res_err(res_err), .limit(limit), .line_done(line_done),
    .worst_idx(worst_idx), .worst_code(worst_code), .line_fail(line_fail)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic void expect_grp(input int g, output int code, output bit err);
    longint mx = 0, mn = 1 << DW, sm = 0, q;
    for (int k = 0; k < N; k++) begin
      int v = pix[g*N + k];
      if (v > mx) mx = v;
      if (v < mn) mn = v;
      sm += v;
    end
    if (sm == 0) begin
      code = CMAX; err = 1'b1;
    end else begin
      q = (mx - mn) * 100 * N / sm;
      code = (q > CMAX) ? CMAX : int'(q);
      err = 1'b0;
    end
  endfunction

  // Streams pix[] as one line and checks R3..R8 (R10 where the data saturates)
  task automatic run_line(input int seed);
    int ecode[G];
    bit eerr[G];
    int widx = 0, wcode = -1;
    int idx = 0, got = 0, stall, cyc = 0;
    bit exp_done = 1'b0;
    for (int g = 0; g < G; g++) begin
      expect_grp(g, ecode[g], eerr[g]);
      if (ecode[g] > wcode) begin wcode = ecode[g]; widx = g; end
    end
    stall = seed % 3;
    while ((got < G || exp_done) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
      if (exp_done) begin
        chk(line_done == 1'b1, "R7 done pulse", line_done, 1);
        chk(worst_idx == IW'(widx), "R7 worst index", worst_idx, widx);
        chk(worst_code == RW'(wcode), "R7 worst code", worst_code, wcode);
        chk(line_fail == (wcode > int'(limit)), "R8 fail flag", line_fail, wcode > int'(limit));
        exp_done = 1'b0;
      end else if (line_done) begin
        chk(1'b0, "R7 stray done", line_done, 0);
      end
      if (res_valid) begin
        chk(in_ready == 1'b0, "R6 intake blocked", in_ready, 0);
        if (stall > 0) begin
          res_ready = 1'b0;
          stall--;
        end else begin
          res_ready = 1'b1;
          chk(res_idx == IW'(got), "R3 group index", res_idx, got);
          chk(res_code == RW'(ecode[got]), "R4 R10 group code", res_code, ecode[got]);
          chk(res_err == eerr[got], "R5 error flag", res_err, eerr[got]);
          got++;
          if (got == G) exp_done = 1'b1;
          stall = (got + seed) % 3;
        end
      end else begin
        res_ready = 1'b0;
      end
      if (idx < T) begin
        in_valid = 1'b1;
        in_data  = DW'(pix[idx]);
        in_sol   = (idx == 0);
        if (in_ready) idx++;
      end else begin
        in_valid = 1'b0;
        in_sol   = 1'b0;
      end
    end
    chk(got == G, "R3 results per line", got, G);
    @(negedge clk);
    in_valid  = 1'b0;
    in_sol    = 1'b0;
    res_ready = 1'b0;
  endtask

  // Sends pixels without a line start and checks nothing comes out (R2, R9)
  task automatic send_orphans(input string req);
    bit seen = 1'b0;
    for (int k = 0; k < 2 * N + 1; k++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sol   = 1'b0;
      in_data  = DW'(10 + 40 * (k % 3));
      chk(in_ready == 1'b1, req, in_ready, 1);
    end
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      res_ready = 1'b1;
      if (res_valid || line_done) seen = 1'b1;
    end
    res_ready = 1'b0;
    chk(!seen, req, seen, 0);
  endtask

  initial begin
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    chk(1'b0, "watchdog", cycles, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1 ready at reset", in_ready, 1);
    chk(res_valid == 1'b0, "R1 no result at reset", res_valid, 0);
    chk(line_done == 1'b0, "R1 no done at reset", line_done, 0);
    rst_n = 1'b1;

    send_orphans("R2 no line start");

    for (int i = 0; i < T; i++) pix[i] = 100;
    limit = 8'd40;
    run_line(0);

    send_orphans("R9 after line end");

    for (int i = 0; i < T; i++) pix[i] = 90 + (i * 37) % 23;
    limit = 8'd20;
    run_line(1);

    // group 0 saturates, group 1 is all zero, group 2 ties group 0 at full scale
    pix = '{0, 0, 0, 255, 0, 0, 0, 0, 0, 0, 0, 200};
    limit = 8'd254;
    run_line(2);

    // two equal nonzero scores: the lower index must win
    pix = '{100, 100, 100, 120, 50, 50, 50, 50, 100, 100, 100, 120};
    limit = 8'd80;
    run_line(0);

    for (int s = 1; s <= 40; s++) begin
      for (int i = 0; i < T; i++) pix[i] = 60 + ((i * (s + 3) + s * s) % (s * 4 + 1));
      limit = RW'(s * 6);
      run_line(s);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule